// File: doc/BRIEF.md
# USB Host Channel Halt Controller

This block governs the start and stop of a small group of USB host channels. Each running channel places transaction requests into one of two shared request queues. Bulk and control channels use the non-periodic queue. Isochronous and interrupt channels use the periodic queue. Each queue entry carries the number of the channel that posted it.

Software reaches the block through a single control write per cycle. A write names a channel and carries an enable bit and a disable bit. Enable alone starts an idle channel. Both bits together ask for a halt. Disable alone removes the channel's queued requests and changes nothing else. A halt removes the channel's queued requests at once. If a bus transaction is still running for that channel, the block waits for it to finish. It then raises a sticky halted interrupt, and only then frees the channel for reuse.

A bus-side consumer pops entries from the head of each queue. When queued requests are removed, the remaining entries keep their order.

Top module: `usb_hchan_halt`

## Requirements
- R1: After reset, every channel is idle: chan_en, chan_busy, halt_int and halt_err are all zero, and both queue counts are zero.
- R2: A write with wr_enable=1 and wr_disable=0 to an idle channel sets that channel's chan_en and chan_busy at the next clock edge. chan_en is never 1 while chan_busy is 0.
- R3: Channel types are coded 00 control, 01 isochronous, 10 bulk, 11 interrupt. Bit 0 set selects the periodic queue. A running channel that raises post_req has its number appended to its queue, and post_ack is high in that same cycle. When several channels compete for one queue, the lowest-numbered channel wins. No request is accepted from a channel that is not running, or into a queue that already holds QDEPTH entries. A count never exceeds QDEPTH.
- R4: A pop (np_pop or p_pop) on a non-empty queue removes its head entry. Entries leave the queue in the order they arrived.
- R5: A halt write (wr_enable=1, wr_disable=1) to a running channel whose matching queue holds fewer than QDEPTH entries does three things at the next edge: it removes every entry tagged with that channel, it keeps the other entries in order, and it clears chan_en.
- R6: If xact_active for that channel is low in the halt-write cycle, halt_int sets at the next edge. Otherwise halt_int stays low and chan_busy stays high until the edge that ends the first cycle in which xact_active is low.
- R7: chan_busy falls only at the edge where the channel's halt_int is set by a completed halt.
- R8: A halt write to a running channel whose matching queue holds QDEPTH entries is rejected. At the next edge, halt_err sets, chan_en stays 1, no entry is removed and halt_int is not raised.
- R9: A write with wr_disable=1 and wr_enable=0 removes the named channel's queued entries and keeps the others in order. chan_en, chan_busy and halt_int are unchanged.
- R10: halt_int and halt_err are sticky. Each clears when its own clear input bit is written as 1. If a set and a clear arrive in the same cycle, the set wins.
- R11: The following writes have no effect: any write with wr_valid=0, a halt to an idle channel, and an enable to a running or draining channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Control write strobe |
| wr_chan | input | CHW | Channel addressed by the write |
| wr_enable | input | 1 | Enable bit of the write |
| wr_disable | input | 1 | Disable bit of the write |
| chan_type | input | 2*NCH | Two-bit type per channel (00 ctrl, 01 iso, 10 bulk, 11 intr) |
| xact_active | input | NCH | A bus transaction is in flight for the channel |
| post_req | input | NCH | The channel offers a request for its queue |
| post_ack | output | NCH | The request was taken this cycle |
| int_clr | input | NCH | Write-1 clear of halt_int |
| err_clr | input | NCH | Write-1 clear of halt_err |
| np_pop | input | 1 | Remove the head of the non-periodic queue |
| p_pop | input | 1 | Remove the head of the periodic queue |
| np_count | output | CW | Entries in the non-periodic queue |
| p_count | output | CW | Entries in the periodic queue |
| np_head | output | CHW | Channel tag at the non-periodic head |
| p_head | output | CHW | Channel tag at the periodic head |
| chan_en | output | NCH | The channel is running |
| chan_busy | output | NCH | The channel is allocated and not yet halted |
| halt_int | output | NCH | Sticky halted interrupt |
| halt_err | output | NCH | Sticky rejected-halt flag |

## Verification
The assertions check these invariants on every cycle:
- An enabled channel is always busy.
- Busy drops only together with a set halted interrupt.
- A halted interrupt never rises while the previous cycle still showed a running transaction.
- Acceptance is granted only to running channels that ask.
- Queue counts stay within range.
- A halt against a full queue leaves the channel enabled and flags the error.

The bench scenarios show what a cycle-local property cannot:
- Flushed entries vanish while the survivors keep their order.
- A halt stays pending through a multi-cycle transaction.
- Disable-only writes reshape a full queue and leave the channel state alone.
- Sticky flags clear only through their own clear inputs.

// File: rtl/hc_pkg.sv
package hc_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_RUN   = 2'd1,
        CH_DRAIN = 2'd2
    } ch_state_e;

    localparam logic [1:0] TYPE_CTRL = 2'b00;
    localparam logic [1:0] TYPE_ISO  = 2'b01;
    localparam logic [1:0] TYPE_BULK = 2'b10;
    localparam logic [1:0] TYPE_INTR = 2'b11;

    localparam int Q_NONPER = 0;
    localparam int Q_PER    = 1;
    localparam int NUM_Q    = 2;

    function automatic logic type_is_periodic(input logic [1:0] t);
        return t[0];
    endfunction

endpackage

// File: rtl/hc_chan_fsm.sv
module hc_chan_fsm
    import hc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_en_bit,
    input  logic wr_dis_bit,
    input  logic q_full,
    input  logic xact_busy,
    input  logic int_clr,
    input  logic err_clr,
    output logic run,
    output logic busy,
    output logic halted_int,
    output logic halt_err,
    output logic flush_req
);

    typedef struct packed {
        ch_state_e st;
        logic      intr;
        logic      err;
    } fsm_s;

    fsm_s cur_q, cur_d;
    logic halt_wr, dis_only, en_only;

    always_comb begin
        cur_d     = cur_q;
        flush_req = 1'b0;
        halt_wr   = wr_hit & wr_en_bit & wr_dis_bit;
        dis_only  = wr_hit & wr_dis_bit & ~wr_en_bit;
        en_only   = wr_hit & wr_en_bit & ~wr_dis_bit;

        // clears first so that a same-cycle set takes precedence
        if (int_clr) cur_d.intr = 1'b0;
        if (err_clr) cur_d.err  = 1'b0;

        if (dis_only) flush_req = 1'b1;

        unique case (cur_q.st)
            CH_IDLE: begin
                if (en_only) cur_d.st = CH_RUN;
            end
            CH_RUN: begin
                if (halt_wr) begin
                    if (q_full) begin
                        cur_d.err = 1'b1;
                    end else begin
                        flush_req = 1'b1;
                        if (xact_busy) begin
                            cur_d.st = CH_DRAIN;
                        end else begin
                            cur_d.st   = CH_IDLE;
                            cur_d.intr = 1'b1;
                        end
                    end
                end
            end
            CH_DRAIN: begin
                if (!xact_busy) begin
                    cur_d.st   = CH_IDLE;
                    cur_d.intr = 1'b1;
                end
            end
            default: cur_d.st = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: CH_IDLE, intr: 1'b0, err: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign run        = (cur_q.st == CH_RUN);
    assign busy       = (cur_q.st != CH_IDLE);
    assign halted_int = cur_q.intr;
    assign halt_err   = cur_q.err;

endmodule

// File: rtl/hc_post_arb.sv
module hc_post_arb #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] req,
    input  logic           allow,
    output logic [NCH-1:0] gnt,
    output logic           gnt_any,
    output logic [CHW-1:0] gnt_idx
);

    always_comb begin
        gnt     = '0;
        gnt_any = 1'b0;
        gnt_idx = '0;
        if (allow) begin
            for (int i = 0; i < NCH; i++) begin
                if (req[i] && !gnt_any) begin
                    gnt[i]  = 1'b1;
                    gnt_any = 1'b1;
                    gnt_idx = CHW'(i);
                end
            end
        end
    end

endmodule

// File: rtl/hc_req_queue.sv
module hc_req_queue #(
    parameter int DEPTH = 8,
    parameter int TAGW  = 2,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [TAGW-1:0] push_tag,
    input  logic            pop,
    input  logic            flush,
    input  logic [TAGW-1:0] flush_tag,
    output logic [CW-1:0]   count,
    output logic [TAGW-1:0] head,
    output logic            full
);

    typedef struct packed {
        logic [DEPTH-1:0][TAGW-1:0] slot;
        logic [CW-1:0]              cnt;
    } q_s;

    q_s cur_q, cur_d;
    logic [CW-1:0] wr_idx;

    always_comb begin
        cur_d      = cur_q;
        cur_d.slot = '0;
        wr_idx     = '0;
        // keep every live entry that is neither popped nor flushed, in order
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < cur_q.cnt) begin
                if (!(i == 0 && pop) && !(flush && cur_q.slot[i] == flush_tag)) begin
                    cur_d.slot[wr_idx[IW-1:0]] = cur_q.slot[i];
                    wr_idx = wr_idx + 1'b1;
                end
            end
        end
        if (push && (cur_q.cnt < CW'(DEPTH)) && (wr_idx < CW'(DEPTH))) begin
            cur_d.slot[wr_idx[IW-1:0]] = push_tag;
            wr_idx = wr_idx + 1'b1;
        end
        cur_d.cnt = wr_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign count = cur_q.cnt;
    assign head  = cur_q.slot[0];
    assign full  = (cur_q.cnt == CW'(DEPTH));

endmodule

// File: rtl/usb_hchan_halt.sv
module usb_hchan_halt
    import hc_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int QDEPTH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CW  = $clog2(QDEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [CHW-1:0]   wr_chan,
    input  logic             wr_enable,
    input  logic             wr_disable,
    input  logic [2*NCH-1:0] chan_type,
    input  logic [NCH-1:0]   xact_active,
    input  logic [NCH-1:0]   post_req,
    output logic [NCH-1:0]   post_ack,
    input  logic [NCH-1:0]   int_clr,
    input  logic [NCH-1:0]   err_clr,
    input  logic             np_pop,
    input  logic             p_pop,
    output logic [CW-1:0]    np_count,
    output logic [CW-1:0]    p_count,
    output logic [CHW-1:0]   np_head,
    output logic [CHW-1:0]   p_head,
    output logic [NCH-1:0]   chan_en,
    output logic [NCH-1:0]   chan_busy,
    output logic [NCH-1:0]   halt_int,
    output logic [NCH-1:0]   halt_err
);

    logic [NCH-1:0] wr_hit;
    logic [NCH-1:0] is_per;
    logic [NCH-1:0] flush_req;
    logic [NCH-1:0] ch_qfull;
    logic [NCH-1:0] eligible;

    logic [NUM_Q-1:0]           q_full;
    logic [NUM_Q-1:0]           q_pop;
    logic [NUM_Q-1:0]           q_flush;
    logic [NUM_Q-1:0][CW-1:0]   q_count;
    logic [NUM_Q-1:0][CHW-1:0]  q_head;
    logic [NUM_Q-1:0][NCH-1:0]  q_gnt;

    assign q_pop[Q_NONPER] = np_pop;
    assign q_pop[Q_PER]    = p_pop;

    genvar gc, gq;
    generate
        for (gc = 0; gc < NCH; gc++) begin : g_chan
            assign wr_hit[gc]   = wr_valid && (wr_chan == CHW'(gc));
            assign is_per[gc]   = type_is_periodic(chan_type[2*gc +: 2]);
            assign ch_qfull[gc] = is_per[gc] ? q_full[Q_PER] : q_full[Q_NONPER];
            // a channel receiving any disable write posts nothing that cycle
            assign eligible[gc] = post_req[gc] & chan_en[gc] & ~(wr_hit[gc] & wr_disable);

            hc_chan_fsm u_fsm (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_hit     (wr_hit[gc]),
                .wr_en_bit  (wr_enable),
                .wr_dis_bit (wr_disable),
                .q_full     (ch_qfull[gc]),
                .xact_busy  (xact_active[gc]),
                .int_clr    (int_clr[gc]),
                .err_clr    (err_clr[gc]),
                .run        (chan_en[gc]),
                .busy       (chan_busy[gc]),
                .halted_int (halt_int[gc]),
                .halt_err   (halt_err[gc]),
                .flush_req  (flush_req[gc])
            );
        end

        for (gq = 0; gq < NUM_Q; gq++) begin : g_queue
            logic [NCH-1:0] sel_mask;
            logic           push_any;
            logic [CHW-1:0] push_tag;

            assign sel_mask     = (gq == Q_PER) ? is_per : ~is_per;
            assign q_flush[gq]  = |(flush_req & sel_mask);

            hc_post_arb #(.NCH(NCH)) u_arb (
                .req     (eligible & sel_mask),
                .allow   (~q_full[gq]),
                .gnt     (q_gnt[gq]),
                .gnt_any (push_any),
                .gnt_idx (push_tag)
            );

            hc_req_queue #(.DEPTH(QDEPTH), .TAGW(CHW)) u_q (
                .clk       (clk),
                .rst_n     (rst_n),
                .push      (push_any),
                .push_tag  (push_tag),
                .pop       (q_pop[gq] && (q_count[gq] != '0)),
                .flush     (q_flush[gq]),
                .flush_tag (wr_chan),
                .count     (q_count[gq]),
                .head      (q_head[gq]),
                .full      (q_full[gq])
            );
        end
    endgenerate

    assign post_ack = q_gnt[Q_NONPER] | q_gnt[Q_PER];
    assign np_count = q_count[Q_NONPER];
    assign p_count  = q_count[Q_PER];
    assign np_head  = q_head[Q_NONPER];
    assign p_head   = q_head[Q_PER];

endmodule

// File: rtl/hc_halt_checker.sv
module hc_halt_checker #(
    parameter int NCH    = 4,
    parameter int QDEPTH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int CW  = $clog2(QDEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid,
    input logic [CHW-1:0]   wr_chan,
    input logic             wr_enable,
    input logic             wr_disable,
    input logic [2*NCH-1:0] chan_type,
    input logic [NCH-1:0]   xact_active,
    input logic [NCH-1:0]   post_req,
    input logic [NCH-1:0]   post_ack,
    input logic [CW-1:0]    np_count,
    input logic [CW-1:0]    p_count,
    input logic [NCH-1:0]   chan_en,
    input logic [NCH-1:0]   chan_busy,
    input logic [NCH-1:0]   halt_int,
    input logic [NCH-1:0]   halt_err
);

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (np_count <= CW'(QDEPTH)) && (p_count <= CW'(QDEPTH)));

    genvar gi;
    generate
        for (gi = 0; gi < NCH; gi++) begin : g_chk
            logic match_full;
            assign match_full = chan_type[2*gi] ? (p_count == CW'(QDEPTH))
                                                : (np_count == CW'(QDEPTH));

            p_en_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
                chan_en[gi] |-> chan_busy[gi]);

            p_busy_int_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(chan_busy[gi]) |-> halt_int[gi]);

            p_int_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(halt_int[gi]) |-> !chan_busy[gi]);

            p_no_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(halt_int[gi]) |-> !$past(xact_active[gi]));

            p_ack_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
                post_ack[gi] |-> (chan_en[gi] && post_req[gi]));

            p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_valid && wr_enable && wr_disable && wr_chan == CHW'(gi)
                 && chan_en[gi] && match_full)
                |=> (chan_en[gi] && halt_err[gi] && !$rose(halt_int[gi])));
        end
    endgenerate

endmodule

bind usb_hchan_halt hc_halt_checker #(.NCH(NCH), .QDEPTH(QDEPTH)) u_chk (.*);

// File: tb/usb_hchan_halt_tb.sv
module usb_hchan_halt_tb;

    localparam int NCH = 4;
    localparam int QD  = 8;
    localparam int CHW = 2;
    localparam int CW  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_valid = 1'b0;
    logic [CHW-1:0]   wr_chan = '0;
    logic             wr_enable = 1'b0;
    logic             wr_disable = 1'b0;
    // ch0 ctrl, ch1 iso, ch2 bulk, ch3 interrupt
    logic [2*NCH-1:0] chan_type = {2'b11, 2'b10, 2'b01, 2'b00};
    logic [NCH-1:0]   xact_active = '0;
    logic [NCH-1:0]   post_req = '0;
    logic [NCH-1:0]   post_ack;
    logic [NCH-1:0]   int_clr = '0;
    logic [NCH-1:0]   err_clr = '0;
    logic             np_pop = 1'b0;
    logic             p_pop = 1'b0;
    logic [CW-1:0]    np_count, p_count;
    logic [CHW-1:0]   np_head, p_head;
    logic [NCH-1:0]   chan_en, chan_busy, halt_int, halt_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    usb_hchan_halt #(.NCH(NCH), .QDEPTH(QD)) u_dut (.*);

    // {vld, ch, en, dis, exp_en, exp_busy, exp_int}
    localparam int NV = 12;
    localparam logic [16:0] VEC [NV] = '{
        {1'b1, 2'd0, 1'b1, 1'b0, 4'b0001, 4'b0001, 4'b0000}, // R2 start ch0
        {1'b1, 2'd2, 1'b1, 1'b0, 4'b0101, 4'b0101, 4'b0000}, // R2 start ch2
        {1'b0, 2'd1, 1'b1, 1'b0, 4'b0101, 4'b0101, 4'b0000}, // R11 no strobe
        {1'b1, 2'd1, 1'b1, 1'b1, 4'b0101, 4'b0101, 4'b0000}, // R11 halt idle
        {1'b1, 2'd0, 1'b1, 1'b1, 4'b0100, 4'b0100, 4'b0001}, // R6 halt ch0
        {1'b1, 2'd0, 1'b1, 1'b0, 4'b0101, 4'b0101, 4'b0001}, // R10 int sticky
        {1'b1, 2'd2, 1'b0, 1'b1, 4'b0101, 4'b0101, 4'b0001}, // R9 flush only
        {1'b1, 2'd2, 1'b1, 1'b0, 4'b0101, 4'b0101, 4'b0001}, // R11 enable running
        {1'b1, 2'd2, 1'b1, 1'b1, 4'b0001, 4'b0001, 4'b0101}, // R6 halt ch2
        {1'b1, 2'd3, 1'b1, 1'b0, 4'b1001, 4'b1001, 4'b0101}, // R2 start ch3
        {1'b1, 2'd3, 1'b1, 1'b1, 4'b0001, 4'b0001, 4'b1101}, // R6 halt ch3
        {1'b1, 2'd0, 1'b1, 1'b1, 4'b0000, 4'b0000, 4'b1101}  // R7 halt ch0 again
    };

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic cwrite(input int ch, input logic en, input logic dis);
        wr_valid   = 1'b1;
        wr_chan    = CHW'(ch);
        wr_enable  = en;
        wr_disable = dis;
        tick();
        wr_valid   = 1'b0;
        wr_enable  = 1'b0;
        wr_disable = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(32'(chan_en), 0, "R1 chan_en");
        chk(32'(chan_busy), 0, "R1 chan_busy");
        chk(32'(halt_int | halt_err), 0, "R1 flags");
        chk(32'(np_count + p_count), 0, "R1 counts");

        for (int v = 0; v < NV; v++) begin
            wr_valid   = VEC[v][16];
            wr_chan    = VEC[v][15:14];
            wr_enable  = VEC[v][13];
            wr_disable = VEC[v][12];
            tick();
            wr_valid = 1'b0;
            chk(32'(chan_en),   32'(VEC[v][11:8]), $sformatf("R2 vec%0d chan_en", v));
            chk(32'(chan_busy), 32'(VEC[v][7:4]),  $sformatf("R7 vec%0d chan_busy", v));
            chk(32'(halt_int),  32'(VEC[v][3:0]),  $sformatf("R6 vec%0d halt_int", v));
        end

        // R10 write-1 clear of selected bits
        int_clr = 4'b0101;
        tick();
        int_clr = '0;
        chk(32'(halt_int), 32'b1000, "R10 partial int clear");
        int_clr = 4'b1000;
        tick();
        int_clr = '0;

        // R3 posting and arbitration
        cwrite(0, 1'b1, 1'b0);
        cwrite(1, 1'b1, 1'b0);
        cwrite(2, 1'b1, 1'b0);
        post_req = 4'b0111;
        #1;
        chk(32'(post_ack), 32'b0011, "R3 lowest index wins per queue");
        tick();
        post_req = '0;
        chk(32'(np_count), 1, "R3 np count");
        chk(32'(p_count), 1, "R3 p count");
        chk(32'(p_head), 1, "R3 periodic routing");
        for (int k = 0; k < 7; k++) begin
            post_req = (k % 2 == 0) ? 4'b0100 : 4'b0001;
            tick();
        end
        post_req = '0;
        chk(32'(np_count), 8, "R3 np full");
        post_req = 4'b0001;
        #1;
        chk(32'(post_ack), 0, "R3 no accept when full");
        post_req = 4'b1000;
        #1;
        chk(32'(post_ack), 0, "R3 no accept from idle ch3");
        post_req = '0;

        // R8 rejected halt on full queue
        cwrite(2, 1'b1, 1'b1);
        chk(32'(halt_err[2]), 1, "R8 err set");
        chk(32'(chan_en[2]), 1, "R8 stays enabled");
        chk(32'(np_count), 8, "R8 nothing flushed");
        chk(32'(halt_int[2]), 0, "R8 no interrupt");

        // R9 disable-only flush on the full queue: 0,2,0,2,0,2,0,2 -> 0,0,0,0
        cwrite(2, 1'b0, 1'b1);
        chk(32'(np_count), 4, "R9 ch2 entries removed");
        chk(32'(chan_en[2]), 1, "R9 channel state kept");
        chk(32'(halt_int[2]), 0, "R9 no interrupt");
        post_req = 4'b0100;
        tick();
        post_req = '0;
        chk(32'(np_count), 5, "R3 repost after flush");

        // R4 order kept across pops
        np_pop = 1'b1;
        repeat (4) tick();
        np_pop = 1'b0;
        chk(32'(np_count), 1, "R4 count after pops");
        chk(32'(np_head), 2, "R4 surviving order");

        // R6 halt while a transaction is on the bus
        xact_active[2] = 1'b1;
        cwrite(2, 1'b1, 1'b1);
        chk(32'(chan_en[2]), 0, "R5 enable cleared");
        chk(32'(np_count), 0, "R5 entry flushed");
        chk(32'(chan_busy[2]), 1, "R6 busy held");
        cwrite(2, 1'b1, 1'b0); // R11 enable while draining
        tick();
        chk(32'(chan_en[2]), 0, "R11 enable ignored while draining");
        chk(32'(halt_int[2]), 0, "R6 interrupt withheld");
        chk(32'(chan_busy[2]), 1, "R7 busy while draining");
        xact_active[2] = 1'b0;
        tick();
        chk(32'(halt_int[2]), 1, "R6 interrupt after transaction");
        chk(32'(chan_busy[2]), 0, "R7 busy released");

        // R10 error flag clear
        err_clr = 4'b0100;
        tick();
        err_clr = '0;
        chk(32'(halt_err), 0, "R10 err cleared");

        // R5 periodic halt flushes the periodic queue
        cwrite(1, 1'b1, 1'b1);
        chk(32'(p_count), 0, "R5 periodic flush");
        chk(32'(halt_int[1]), 1, "R5 periodic halt interrupt");
        chk(32'(chan_en[1]), 0, "R5 periodic enable cleared");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule